// File: doc/BRIEF.md
# Strided Prefetching Stream Buffer

This block feeds a processing element with a continuous stream of data words that it fetches from memory before they are asked for. A one-cycle start pulse captures a base address, a stride, an element count and an access mode. An address generator then issues read requests on a memory request port with a valid/ready handshake. The memory returns words on a response port after any latency, in request order. The returned words are queued and handed to the consumer on a valid/ready output stream.

Three access modes exist. Sequential mode walks consecutive elements. Strided mode adds a constant element stride each time, so it can gather a matrix column. Indirect mode reads one entry of a separate index stream per request and offsets the base by that entry. Prefetch is limited by queue space, not by consumer demand. Requests in flight plus words already queued never exceed the queue depth, so every response has a free slot and the response port needs no ready signal.

Back-pressure rules: the memory request and the index word stay stable while they are valid and not yet accepted. The index source must hold `idx_valid` and `idx_data` until `idx_ready`. The consumer may hold `out_ready` low for any length of time. The output word stays in place until it is taken.

Top module: `stride_stream_buffer`

## Requirements
- R1: While reset is held and right after it, `busy`, `done`, `out_valid`, `mem_req_valid` and `idx_ready` are 0.
- R2: With `cfg_mode` 0, or the reserved value 3, request k (from 0) has address base + k*EB, where EB is the element size in bytes (default 4). All address arithmetic wraps modulo 2^AW.
- R3: With `cfg_mode` 1, request k has address base + k*stride*EB, wrapping modulo 2^AW. The stride may be any value, including one that acts as negative.
- R4: With `cfg_mode` 2, each request has address base + idx*EB, where idx is the next index word. An index word is accepted (`idx_valid` and `idx_ready`) in exactly the cycle its request is accepted.
- R5: Output words appear in the order their addresses were issued. Each output word is the response to that request.
- R6: Requests are issued without waiting for the consumer. While `out_ready` stays low, requests continue until requests in flight plus queued words equal DEPTH (or the count is used up), and then stop.
- R7: No request is issued when requests in flight plus queued words already equal DEPTH. `out_valid` is never 1 while no word is queued.
- R8: Exactly `cfg_count` requests are issued per stream. `done` rises in the cycle after the last word is consumed, and stays high until the next accepted start. A count of 0 sets `done` in the cycle after start and issues nothing.
- R9: A start pulse while `busy` is 1 is ignored. The running stream keeps its addresses and its count.
- R10: A request that is valid but not accepted stays valid with the same address in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Pulse that captures the configuration when idle |
| cfg_base | input | AW | Base byte address |
| cfg_stride | input | AW | Stride in elements (strided mode) |
| cfg_count | input | CNTW | Number of elements in the stream |
| cfg_mode | input | 2 | 0 sequential, 1 strided, 2 indirect, 3 treated as sequential |
| busy | output | 1 | Stream in progress |
| done | output | 1 | Last element consumed; sticky until next start |
| idx_valid | input | 1 | Index word available |
| idx_ready | output | 1 | Index word taken this cycle |
| idx_data | input | AW | Index in elements |
| mem_req_valid | output | 1 | Read request valid |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | AW | Read byte address |
| mem_rsp_valid | input | 1 | Response word valid, in request order |
| mem_rsp_data | input | DW | Response word |
| out_valid | output | 1 | Output word available |
| out_ready | input | 1 | Consumer takes the word |
| out_data | output | DW | Output word |

## Verification
The bench builds the block with DEPTH=4, AW=32, DW=32 and EB=4. With the small queue, the credit limit is reached in almost every stream, so stalls on a full queue and resumption after a pop happen often. Streams of up to 40 elements are longer than the queue many times over. With 32-bit random bases and strides, address wrap-around in both directions is tested. A directed stream with exactly DEPTH elements and one with zero elements cover the count boundaries.

// File: rtl/ssb_pkg.sv
package ssb_pkg;
  typedef enum logic [1:0] {
    SSB_SEQ    = 2'd0,
    SSB_STRIDE = 2'd1,
    SSB_INDIR  = 2'd2,
    SSB_RSVD   = 2'd3
  } ssb_mode_e;
endpackage

// File: rtl/ssb_fifo.sv
module ssb_fifo #(
  parameter int DW    = 32,
  parameter int DEPTH = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_en,
  output logic [DW-1:0] rd_data,
  output logic          empty
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

  logic [DW-1:0] store [DEPTH];
  logic [PW-1:0] wp, rp;
  logic [CW-1:0] fill;

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == LAST) ? '0 : p + PW'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (wr_en) store[wp] <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp   <= '0;
      rp   <= '0;
      fill <= '0;
    end else begin
      if (wr_en) wp <= bump(wp);
      if (rd_en) rp <= bump(rp);
      fill <= fill + CW'(wr_en) - CW'(rd_en);
    end
  end

  assign rd_data = store[rp];
  assign empty   = (fill == '0);
endmodule

// File: rtl/ssb_credit.sv
module ssb_credit #(
  parameter int DEPTH = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic take,
  input  logic give,
  output logic room
);
  localparam int CW = $clog2(DEPTH + 1);
  logic [CW-1:0] used;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) used <= '0;
    else        used <= used + CW'(take) - CW'(give);
  end

  assign room = (used < CW'(DEPTH));
endmodule

// File: rtl/ssb_addr_gen.sv
module ssb_addr_gen
  import ssb_pkg::*;
#(
  parameter int AW   = 32,
  parameter int CNTW = 16,
  parameter int EB   = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic [AW-1:0]   base,
  input  logic [AW-1:0]   stride,
  input  logic [CNTW-1:0] count,
  input  logic [1:0]      mode,
  input  logic            advance,
  input  logic [AW-1:0]   idx,
  output logic [AW-1:0]   addr,
  output logic            pending,
  output logic            indir
);
  localparam bit POW2 = ((EB & (EB - 1)) == 0);
  localparam int SH   = (EB > 1) ? $clog2(EB) : 0;

  logic [AW-1:0]   stride_sel, step_in, idx_off;
  logic [AW-1:0]   base_q, step_q, cur_q;
  logic [CNTW-1:0] rem_q;
  logic            indir_q;

  assign stride_sel = (ssb_mode_e'(mode) == SSB_STRIDE) ? stride : AW'(1);

  generate
    if (POW2) begin : g_shift
      assign step_in = stride_sel << SH;
      assign idx_off = idx << SH;
    end else begin : g_mult
      assign step_in = stride_sel * AW'(EB);
      assign idx_off = idx * AW'(EB);
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q  <= '0;
      step_q  <= '0;
      cur_q   <= '0;
      rem_q   <= '0;
      indir_q <= 1'b0;
    end else if (load) begin
      base_q  <= base;
      step_q  <= step_in;
      cur_q   <= base;
      rem_q   <= count;
      indir_q <= (ssb_mode_e'(mode) == SSB_INDIR);
    end else if (advance) begin
      cur_q <= cur_q + step_q;
      rem_q <= rem_q - CNTW'(1);
    end
  end

  assign addr    = indir_q ? (base_q + idx_off) : cur_q;
  assign pending = (rem_q != '0);
  assign indir   = indir_q;
endmodule

// File: rtl/stride_stream_buffer.sv
module stride_stream_buffer #(
  parameter int AW    = 32,
  parameter int DW    = 32,
  parameter int CNTW  = 16,
  parameter int DEPTH = 8,
  parameter int EB    = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [AW-1:0]   cfg_base,
  input  logic [AW-1:0]   cfg_stride,
  input  logic [CNTW-1:0] cfg_count,
  input  logic [1:0]      cfg_mode,
  output logic            busy,
  output logic            done,
  input  logic            idx_valid,
  output logic            idx_ready,
  input  logic [AW-1:0]   idx_data,
  output logic            mem_req_valid,
  input  logic            mem_req_ready,
  output logic [AW-1:0]   mem_req_addr,
  input  logic            mem_rsp_valid,
  input  logic [DW-1:0]   mem_rsp_data,
  output logic            out_valid,
  input  logic            out_ready,
  output logic [DW-1:0]   out_data
);
  logic            accept, room, pending, indir, empty;
  logic            req_fire, pop;
  logic            busy_q, done_q;
  logic [CNTW-1:0] left_q;

  assign accept = start && !busy_q;

  ssb_addr_gen #(.AW(AW), .CNTW(CNTW), .EB(EB)) u_agen (
    .clk(clk), .rst_n(rst_n), .load(accept),
    .base(cfg_base), .stride(cfg_stride), .count(cfg_count), .mode(cfg_mode),
    .advance(req_fire), .idx(idx_data),
    .addr(mem_req_addr), .pending(pending), .indir(indir)
  );

  assign mem_req_valid = busy_q && pending && room && (!indir || idx_valid);
  assign req_fire      = mem_req_valid && mem_req_ready;
  assign idx_ready     = busy_q && indir && pending && room && mem_req_ready;

  ssb_credit #(.DEPTH(DEPTH)) u_credit (
    .clk(clk), .rst_n(rst_n), .take(req_fire), .give(pop), .room(room)
  );

  ssb_fifo #(.DW(DW), .DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n),
    .wr_en(mem_rsp_valid), .wr_data(mem_rsp_data),
    .rd_en(pop), .rd_data(out_data), .empty(empty)
  );

  assign out_valid = !empty;
  assign pop       = out_valid && out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      left_q <= '0;
    end else if (accept) begin
      busy_q <= (cfg_count != '0);
      done_q <= (cfg_count == '0);
      left_q <= cfg_count;
    end else if (pop && busy_q) begin
      left_q <= left_q - CNTW'(1);
      if (left_q == CNTW'(1)) begin
        busy_q <= 1'b0;
        done_q <= 1'b1;
      end
    end
  end

  assign busy = busy_q;
  assign done = done_q;
endmodule

// File: rtl/ssb_chk.sv
module ssb_chk #(
  parameter int AW    = 32,
  parameter int CNTW  = 16,
  parameter int DEPTH = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            start,
  input logic            busy,
  input logic            done,
  input logic [CNTW-1:0] cfg_count,
  input logic            mem_req_valid,
  input logic            mem_req_ready,
  input logic [AW-1:0]   mem_req_addr,
  input logic            mem_rsp_valid,
  input logic            out_valid,
  input logic            out_ready
);
  localparam int TW = $clog2(DEPTH + 1) + 1;

  logic [TW-1:0]   held, queued;
  logic [CNTW-1:0] issued, limit;
  logic            fire, take;

  assign fire = mem_req_valid && mem_req_ready;
  assign take = out_valid && out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held   <= '0;
      queued <= '0;
      issued <= '0;
      limit  <= '0;
    end else begin
      held   <= held + TW'(fire) - TW'(take);
      queued <= queued + TW'(mem_rsp_valid) - TW'(take);
      if (start && !busy) begin
        issued <= '0;
        limit  <= cfg_count;
      end else if (fire) begin
        issued <= issued + CNTW'(1);
      end
    end
  end

  // R7
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> held < TW'(DEPTH));

  // R7
  no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> queued != '0);

  // R10
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));

  // R8
  count_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> issued < limit);

  // R8
  done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !mem_req_valid && !out_valid && !busy);
endmodule

bind stride_stream_buffer ssb_chk #(.AW(AW), .CNTW(CNTW), .DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .cfg_count(cfg_count), .mem_req_valid(mem_req_valid),
  .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
  .mem_rsp_valid(mem_rsp_valid), .out_valid(out_valid), .out_ready(out_ready)
);

// File: tb/test_stride_stream_buffer.sv
module test_stride_stream_buffer;
  localparam int AW = 32, DW = 32, CNTW = 16, DEPTH = 4, EB = 4;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic            rst_n, start, busy, done;
  logic [AW-1:0]   cfg_base, cfg_stride, idx_data, mem_req_addr;
  logic [CNTW-1:0] cfg_count;
  logic [1:0]      cfg_mode;
  logic            idx_valid, idx_ready, mem_req_valid, mem_req_ready;
  logic            mem_rsp_valid, out_valid, out_ready;
  logic [DW-1:0]   mem_rsp_data, out_data;

  stride_stream_buffer #(.AW(AW), .DW(DW), .CNTW(CNTW), .DEPTH(DEPTH), .EB(EB)) i_stride_stream_buffer (
    .clk(clk), .rst_n(rst_n), .start(start), .cfg_base(cfg_base),
    .cfg_stride(cfg_stride), .cfg_count(cfg_count), .cfg_mode(cfg_mode),
    .busy(busy), .done(done), .idx_valid(idx_valid), .idx_ready(idx_ready),
    .idx_data(idx_data), .mem_req_valid(mem_req_valid),
    .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
  );

  int total = 0, bad = 0, cyc = 0;
  logic [1:0]  e_mode = 2'd0;
  logic [31:0] e_base = '0, e_stride = '0;
  int          e_count = 0;
  logic [31:0] idx_tab [64];
  int          req_k = 0, out_k = 0, idx_ptr = 0, stored = 0;
  bit          hold_out = 1'b0, prev_stall = 1'b0;
  logic [31:0] prev_addr = '0;
  logic [31:0] q_addr [64];
  int          q_rdy  [64];
  logic [5:0]  wp = '0, rp = '0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_addr(input int k);
    case (e_mode)
      2'd1:    return e_base + 32'(k) * e_stride * 32'(EB);
      2'd2:    return e_base + idx_tab[k] * 32'(EB);
      default: return e_base + 32'(k) * 32'(EB);
    endcase
  endfunction

  function automatic logic [31:0] mem_f(input logic [31:0] a);
    return (a * 32'h9E3779B1) ^ 32'h5A5A1234;
  endfunction

  function automatic string mode_tag();
    case (e_mode)
      2'd1:    return "R3";
      2'd2:    return "R4";
      default: return "R2";
    endcase
  endfunction

  // monitor: samples at the falling edge
  always @(negedge clk) begin
    if (rst_n) begin
      if (out_valid) chk(stored > 0, "R7", "out_valid with nothing queued", 32'(out_valid), 32'd0);
      if (prev_stall)
        chk(mem_req_valid && mem_req_addr == prev_addr, "R10", "stalled request changed",
            mem_req_addr, prev_addr);
      prev_stall = mem_req_valid && !mem_req_ready;
      prev_addr  = mem_req_addr;
      if (e_mode == 2'd2 && ((idx_valid && idx_ready) || (mem_req_valid && mem_req_ready)))
        chk((idx_valid && idx_ready) == (mem_req_valid && mem_req_ready), "R4",
            "index and request accept differ", 32'(idx_valid && idx_ready),
            32'(mem_req_valid && mem_req_ready));
      if (mem_req_valid && mem_req_ready) begin
        chk(req_k < e_count, "R8", "request beyond count", 32'(req_k), 32'(e_count));
        chk(mem_req_addr == exp_addr(req_k), mode_tag(), "request address", mem_req_addr, exp_addr(req_k));
        q_addr[wp] = mem_req_addr;
        q_rdy[wp]  = cyc + 1 + int'($urandom % 6);
        wp = wp + 6'd1;
        req_k++;
      end
      if (idx_valid && idx_ready) idx_ptr++;
      if (mem_rsp_valid) begin
        rp = rp + 6'd1;
        stored++;
      end
      if (out_valid && out_ready) begin
        chk(out_data == mem_f(exp_addr(out_k)), "R5", "output word", out_data, mem_f(exp_addr(out_k)));
        out_k++;
        stored--;
      end
    end
  end

  // driver and watchdog: act just after the rising edge
  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      bad++;
      total++;
      $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 150000);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
    #1;
    if (rst_n) begin
      mem_req_ready = ($urandom % 4) != 0;
      if (rp != wp && q_rdy[rp] <= cyc) begin
        mem_rsp_valid = 1'b1;
        mem_rsp_data  = mem_f(q_addr[rp]);
      end else begin
        mem_rsp_valid = 1'b0;
      end
      out_ready = hold_out ? 1'b0 : (($urandom % 3) != 0);
      if (e_mode == 2'd2 && idx_ptr < e_count) begin
        if (!idx_valid) idx_valid = ($urandom % 4) != 0;
        idx_data = idx_tab[idx_ptr];
      end else begin
        idx_valid = 1'b0;
      end
    end
  end

  task automatic run(input logic [1:0] mode, input logic [31:0] base, input logic [31:0] stride,
                     input int count, input bit hold, input bit poke);
    int t;
    int lim;
    for (int i = 0; i < 64; i++) idx_tab[i] = $urandom;
    e_mode = mode; e_base = base; e_stride = stride; e_count = count;
    req_k = 0; out_k = 0; idx_ptr = 0; hold_out = hold;
    @(posedge clk); #2;
    start = 1'b1; cfg_mode = mode; cfg_base = base; cfg_stride = stride; cfg_count = CNTW'(count);
    @(posedge clk); #2;
    start = 1'b0; cfg_base = $urandom; cfg_stride = $urandom; cfg_mode = 2'd3;
    if (count == 0) begin
      @(negedge clk);
      chk(done && !busy, "R8", "zero count done", {30'd0, done, busy}, 32'd2);
    end
    if (poke) begin
      repeat (3) @(posedge clk);
      #2;
      start = 1'b1; cfg_mode = 2'd0; cfg_base = 32'h0; cfg_count = CNTW'(3);
      @(posedge clk); #2;
      start = 1'b0;
      @(negedge clk);
      chk(busy == 1'b1, "R9", "busy after ignored start", 32'(busy), 32'd1);
    end
    if (hold) begin
      repeat (40) @(posedge clk);
      @(negedge clk);
      lim = (count < DEPTH) ? count : DEPTH;
      chk(req_k == lim, "R6", "requests issued with consumer stalled", 32'(req_k), 32'(lim));
      chk(out_valid == (count > 0), "R6", "prefetched word waiting", 32'(out_valid), 32'(count > 0));
      hold_out = 1'b0;
    end
    t = 0;
    while (!done && t < 5000) begin
      @(negedge clk);
      t++;
    end
    repeat (3) @(negedge clk);
    chk(done && !busy, "R8", "done after last word", {30'd0, done, busy}, 32'd2);
    chk(req_k == count, poke ? "R9" : "R8", "requests per stream", 32'(req_k), 32'(count));
    chk(out_k == count, "R8", "words consumed", 32'(out_k), 32'(count));
  endtask

  initial begin
    void'($urandom(32'd2024));
    rst_n = 1'b0; start = 1'b0; cfg_base = '0; cfg_stride = '0; cfg_count = '0; cfg_mode = '0;
    idx_valid = 1'b0; idx_data = '0; mem_req_ready = 1'b0; mem_rsp_valid = 1'b0;
    mem_rsp_data = '0; out_ready = 1'b0;
    repeat (3) @(negedge clk);
    chk(!busy && !done && !out_valid && !mem_req_valid && !idx_ready, "R1", "outputs in reset",
        {27'd0, busy, done, out_valid, mem_req_valid, idx_ready}, 32'd0);
    @(posedge clk); #2;
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !done && !out_valid && !mem_req_valid && !idx_ready, "R1", "outputs after reset",
        {27'd0, busy, done, out_valid, mem_req_valid, idx_ready}, 32'd0);

    run(2'd0, 32'h0000_1000, 32'd0, 20, 1'b1, 1'b0);          // R2, R6
    run(2'd1, 32'hFFFF_FFF0, 32'd3, 12, 1'b0, 1'b0);          // R3 upward wrap
    run(2'd1, 32'h0000_0040, 32'hFFFF_FFFE, 30, 1'b0, 1'b0);  // R3 downward wrap
    run(2'd2, 32'h0000_8000, 32'd0, 16, 1'b1, 1'b0);          // R4, R6
    run(2'd0, 32'h0000_0200, 32'd0, DEPTH, 1'b0, 1'b0);       // R8 count equals depth
    run(2'd3, 32'h0000_0300, 32'd7, 5, 1'b0, 1'b0);           // R2 reserved mode
    run(2'd0, 32'h0000_0400, 32'd0, 0, 1'b0, 1'b0);           // R8 zero count
    run(2'd1, 32'h0001_0000, 32'd5, 30, 1'b0, 1'b1);          // R9 ignored start
    run(2'd0, 32'h0000_0500, 32'd0, 2, 1'b1, 1'b0);           // R6 below depth
    for (int s = 0; s < 24; s++)
      run(2'($urandom % 3), $urandom, $urandom, 1 + int'($urandom % 40), 1'b0, 1'b0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule